// File: doc/BRIEF.md
# DRAM Distributed Refresh Controller

This block keeps a two-bank dynamic memory array alive by issuing one row-only refresh cycle at regular intervals. A free-running interval timer raises a refresh request a little more often than the nominal per-row period, so that every one of 256 rows is visited within the array's retention window. The request waits until the memory access state machine reports that it is idle. The block then takes over the low address lines for one refresh cycle.

During a refresh cycle the block turns off the low-order row/column address multiplexer and drives its own 8-bit row number onto those lines. It pulls both bank row strobes low together for a fixed number of clocks and never issues a column strobe, so the data pins stay undriven. The strobe width is set to match a read cycle. A precharge gap follows. At the end of the gap the block pulses a done signal and steps the row number by one. The row number wraps from 255 back to 0, so successive refreshes sweep the rows in order. The higher address multiplexers are not touched and stay enabled.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, refPending, refBusy and refDone are 0, ras0N and ras1N are 1, muxOeN is 0, refAddrOeN is 1 and refAddr is 0.
- R2: The interval timer expires every INTERVAL clocks: the first time INTERVAL rising edges after reset is released, then every INTERVAL edges after that. This happens whether or not the previous request has been serviced, and each expiry leaves refPending at 1 after that edge.
- R3: refPending stays 1 until a refresh starts. The edge that starts a refresh clears it, unless the timer expires on that same edge.
- R4: A refresh starts only on an edge where refPending is 1, accIdle is 1 and no refresh is in progress. refBusy is 1 from the next cycle through the end of the precharge gap.
- R5: In the first RAS_CLKS cycles of a refresh, ras0N and ras1N are both 0. At all other times both are 1. The block has no column strobe output.
- R6: The RAS_CLKS strobe cycles are followed by PRE_CLKS precharge cycles with both strobes high and refBusy 1. refDone is 1 in the last precharge cycle only.
- R7: While refBusy is 1, muxOeN is 1 (low multiplexer off) and refAddrOeN is 0 (refresh row driven). While refBusy is 0, muxOeN is 0 and refAddrOeN is 1.
- R8: refAddr shows the current row. It holds that row for the whole refresh and goes up by one on the edge that ends the refresh, wrapping from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accIdle | input | 1 | Memory access state machine is idle, so a refresh may begin |
| refPending | output | 1 | A refresh request is waiting |
| refBusy | output | 1 | A refresh cycle is in progress; the access machine must hold off |
| refDone | output | 1 | Single-cycle pulse in the last cycle of a refresh |
| ras0N | output | 1 | Bank 0 row strobe, active low |
| ras1N | output | 1 | Bank 1 row strobe, active low |
| muxOeN | output | 1 | Output enable of the low-order address multiplexer, active low |
| refAddrOeN | output | 1 | Output enable of the refresh row bus, active low |
| refAddr | output | 8 | Refresh row number |

## Verification
The bench first runs with accIdle held high. Each request is then granted at once, which shows the exact spacing of the timer and the shape of the strobe and precharge windows. It then holds accIdle low across more than two intervals. This separates a request that stays pending from one that is lost or counted twice, and shows that the timer keeps reloading while the request is unserved. It finishes with seeded random idle patterns long enough to sweep all 256 rows. These patterns make timer expiries land on start edges and on busy cycles, and they show the row number wrapping from 255 to 0. Every cycle is compared against a cycle model kept in the bench.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAS  = 2'd1,
    ST_PRE  = 2'd2
  } ref_state_t;

  typedef struct packed {
    logic driveAddr;
    logic strobeRas;
    logic advanceRow;
  } ref_strobe_t;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL = 249,
  parameter int RAS_CLKS = 3,
  parameter int PRE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accIdle,
  output logic        refPending,
  output logic        refBusy,
  output logic        refDone,
  output ref_strobe_t strobe
);
  localparam int CNT_W  = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int PH_MAX = (RAS_CLKS > PRE_CLKS) ? RAS_CLKS : PRE_CLKS;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) + 1 : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INTERVAL - 1);
  localparam logic [PH_W-1:0]  RAS_LOAD = PH_W'(RAS_CLKS - 1);
  localparam logic [PH_W-1:0]  PRE_LOAD = PH_W'(PRE_CLKS - 1);

  ref_state_t       state;
  logic [CNT_W-1:0] ivlCnt;
  logic [PH_W-1:0]  phase;
  logic             pend;
  logic             expiry;
  logic             startRef;
  logic             lastPhase;

  assign expiry    = (ivlCnt == '0);
  assign startRef  = (state == ST_IDLE) && pend && accIdle;
  assign lastPhase = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivlCnt <= CNT_LOAD;
      pend   <= 1'b0;
    end else begin
      ivlCnt <= expiry ? CNT_LOAD : ivlCnt - 1'b1;
      if (expiry)        pend <= 1'b1;
      else if (startRef) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startRef) begin
          state <= ST_RAS;
          phase <= RAS_LOAD;
        end
        ST_RAS: if (lastPhase) begin
          state <= ST_PRE;
          phase <= PRE_LOAD;
        end else begin
          phase <= phase - 1'b1;
        end
        ST_PRE: if (lastPhase) begin
          state <= ST_IDLE;
        end else begin
          phase <= phase - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.driveAddr  = (state != ST_IDLE);
    strobe.strobeRas  = (state == ST_RAS);
    strobe.advanceRow = (state == ST_PRE) && lastPhase;
  end

  assign refPending = pend;
  assign refBusy    = (state != ST_IDLE);
  assign refDone    = strobe.advanceRow;

  logic [PH_W-1:0] rasRun;
  always_ff @(posedge clk) begin
    if (!rstN)                rasRun <= '0;
    else if (state == ST_RAS) rasRun <= rasRun + 1'b1;
    else                      rasRun <= '0;
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAS && $past(state) == ST_IDLE) |-> ($past(accIdle) && $past(pend))); // R4
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !refBusy && !accIdle) |=> pend); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAS && lastPhase) |-> (rasRun == RAS_LOAD)); // R5
  AST_PRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAS && lastPhase) |=> (state == ST_PRE)); // R6
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ref_strobe_t       strobe,
  output logic [ROW_W-1:0]  refAddr,
  output logic              refAddrOeN,
  output logic              muxOeN,
  output logic [NUM_BANKS-1:0] rasN
);
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  rowCnt <= '0;
    else if (strobe.advanceRow) rowCnt <= rowCnt + 1'b1;
  end

  assign refAddr    = rowCnt;
  assign refAddrOeN = ~strobe.driveAddr;
  assign muxOeN     = strobe.driveAddr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rasN[b] = ~strobe.strobeRas;
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advanceRow |=> $stable(rowCnt)); // R8
  AST_ADDR_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    (rasN != '1) |-> (!refAddrOeN && muxOeN)); // R7
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL = 249,
  parameter int RAS_CLKS = 3,
  parameter int PRE_CLKS = 2,
  parameter int ROW_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accIdle,
  output logic             refPending,
  output logic             refBusy,
  output logic             refDone,
  output logic             ras0N,
  output logic             ras1N,
  output logic             muxOeN,
  output logic             refAddrOeN,
  output logic [ROW_W-1:0] refAddr
);
  ref_strobe_t strobe;
  logic [NUM_BANKS-1:0] rasN;

  refresh_ctrl #(
    .INTERVAL(INTERVAL), .RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .accIdle(accIdle),
    .refPending(refPending), .refBusy(refBusy), .refDone(refDone),
    .strobe(strobe)
  );

  refresh_dp #(.ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .refAddr(refAddr), .refAddrOeN(refAddrOeN), .muxOeN(muxOeN), .rasN(rasN)
  );

  assign ras0N = rasN[0];
  assign ras1N = rasN[1];

  AST_BANKS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ras0N) |-> $fell(ras1N)); // R5
endmodule

// File: tb/sim_dram_refresh_ctrl.sv
module sim_dram_refresh_ctrl;
  localparam int INTERVAL = 249;
  localparam int RAS_CLKS = 3;
  localparam int PRE_CLKS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accIdle = 1'b0;
  logic refPending, refBusy, refDone, ras0N, ras1N, muxOeN, refAddrOeN;
  logic [7:0] refAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench cycle model
  int mCnt, mPend, mPh, mLeft, mRow;

  always #2 clk = ~clk;

  dram_refresh_ctrl #(.INTERVAL(INTERVAL), .RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS)) u0 (
    .clk(clk), .rstN(rstN), .accIdle(accIdle),
    .refPending(refPending), .refBusy(refBusy), .refDone(refDone),
    .ras0N(ras0N), .ras1N(ras1N), .muxOeN(muxOeN), .refAddrOeN(refAddrOeN),
    .refAddr(refAddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expBusy();  return (mPh != 0) ? 1 : 0; endfunction
  function automatic int expRasN();  return (mPh == 1) ? 0 : 1; endfunction
  function automatic int expDone();  return (mPh == 2 && mLeft == 0) ? 1 : 0; endfunction

  always @(posedge clk) begin
    if (rstN) begin
      int start, expiry, ph0;
      ph0    = mPh;
      start  = (ph0 == 0 && mPend == 1 && accIdle) ? 1 : 0;
      expiry = (mCnt == 0) ? 1 : 0;
      mCnt   = expiry ? INTERVAL - 1 : mCnt - 1;
      if (expiry) mPend = 1;
      else if (start) mPend = 0;
      if (ph0 == 0) begin
        if (start) begin mPh = 1; mLeft = RAS_CLKS - 1; end
      end else if (ph0 == 1) begin
        if (mLeft == 0) begin mPh = 2; mLeft = PRE_CLKS - 1; end
        else mLeft--;
      end else begin
        if (mLeft == 0) begin mPh = 0; mRow = (mRow + 1) % 256; end
        else mLeft--;
      end
    end
  end

  task automatic compareAll();
    chk("R2", refPending, mPend);
    chk("R4", refBusy, expBusy());
    chk("R5", ras0N, expRasN());
    chk("R5", ras1N, expRasN());
    chk("R6", refDone, expDone());
    chk("R7", muxOeN, expBusy());
    chk("R7", refAddrOeN, 1 - expBusy());
    chk("R8", refAddr, mRow);
  endtask

  task automatic runCycles(input int n, input int idlePct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      accIdle = (($urandom % 100) < idlePct);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    mCnt = INTERVAL - 1; mPend = 0; mPh = 0; mLeft = 0; mRow = 0;
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    chk("R1", refPending, 0); chk("R1", refBusy, 0); chk("R1", refDone, 0);
    chk("R1", ras0N, 1); chk("R1", ras1N, 1); chk("R1", muxOeN, 0);
    chk("R1", refAddrOeN, 1); chk("R1", refAddr, 0);
    rstN = 1'b1;
    accIdle = 1'b1;
    // directed: always idle, each request granted immediately
    runCycles(2000, 100);
    // directed: access machine busy across two expiries, request held (R3)
    runCycles(600, 0);
    chk("R3", refPending, 1);
    chk("R3", refBusy, 0);
    // seeded random idle patterns, long enough for the row to wrap
    runCycles(66000, 70);
    chk("R8", (mRow < 60) ? 1 : 0, 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule